// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Interrupt Routing

This block sits next to a time-of-day counter. It holds two alarm register sets of four bytes each, for seconds, minutes, hours and day. When the counter raises its one-cycle update pulse, the block compares both sets against the current time. Bit 7 of each alarm byte drops that field from the comparison. Setting the bits in a chosen pattern gives an alarm every second, on seconds only, on minutes and seconds, on hours, minutes and seconds, or on the full day and time. A match sets a sticky status flag for that alarm. The flag stays set until software clears it with a strobe or rewrites one of that alarm's bytes.

A control byte holds an oscillator-stop bit, a write-protect bit, a routing bit and two alarm enables. The oscillator-stop bit blocks every comparison. While write-protect is set, every register write is refused except a change to the write-protect bit itself. The two active-low interrupt outputs follow the flags ANDed with their enables. The routing bit either gives each alarm its own output or merges both alarms onto output 0.

Top module: `rtc_alarm_ctrl`

## Requirements
- R1: After reset the control byte reads 0xC0 (oscillator stopped, write-protect set, routing 0, both enables 0), the status byte reads 0x00, both interrupt outputs are high and osc_stop is 1.
- R2: While write-protect (control bit 6) is 1, a write to an alarm byte leaves it unchanged. A write to the control byte changes only bit 6.
- R3: While write-protect is 0, a control write stores bits 7, 6, 2, 1 and 0. Control bits 5 to 3 always read 0.
- R4: An alarm field is left out of the match when bit 7 of its alarm byte is 1. Otherwise bits 6:0 must equal bits 6:0 of the matching time input. An alarm matches when all four fields pass.
- R5: Comparisons happen only in a cycle with upd_tick high while control bit 7 is 0. The flag is visible one cycle later. A tick while the oscillator is stopped has no effect.
- R6: A flag stays set until a stat_clr pulse or an accepted write to any byte of its own alarm clears it. A match in the same cycle as a clear leaves the flag set.
- R7: A flag is set whether or not its enable is on. An interrupt is driven only for an alarm whose enable is 1 (control bit 0 for alarm 0, bit 1 for alarm 1).
- R8: With control bit 2 at 1, alarm 0 drives irq0_n and alarm 1 drives irq1_n. With it at 0, either alarm drives irq0_n and irq1_n stays high.
- R9: Address bit 7 set marks a write. The low seven bits select the register: alarm 0 seconds, minutes, hours and day at 0x00 to 0x03, alarm 1 at 0x04 to 0x07, control at 0x0F, status at 0x10 (bit 0 is flag 0, bit 1 is flag 1, other bits 0). Reading an unmapped address, or any address with bit 7 set, returns 0.
- R10: Both interrupt outputs are active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Qualifies a write in this cycle |
| bus_addr | input | 8 | Register address; bit 7 marks a write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| stat_clr | input | 1 | One-cycle pulse that clears both flags |
| upd_tick | input | 1 | One-cycle time-update pulse from the counter |
| now_sec | input | 8 | Current seconds |
| now_min | input | 8 | Current minutes |
| now_hour | input | 8 | Current hours |
| now_day | input | 8 | Current day |
| osc_stop | output | 1 | Control bit 7; high stops the counter |
| irq0_n | output | 1 | Interrupt output 0, active low |
| irq1_n | output | 1 | Interrupt output 1, active low |

## Verification
The assertions assume that upd_tick and stat_clr are single-cycle pulses. They also assume that the time inputs, address and data hold steady for the whole cycle in which they are sampled, so that a flag rise can always be traced to a tick and a match one cycle earlier. The stimulus changes inputs only on the falling clock edge and holds each pulse for exactly one cycle. Time values are applied together with their tick.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

    localparam int BYTE_W    = 8;
    localparam int FIELD_CNT = 4;
    localparam int ALARM_CNT = 2;
    localparam int REG_AW    = 7;
    localparam int FLD_AW    = $clog2(FIELD_CNT);
    localparam int ALM_AW    = (ALARM_CNT > 1) ? $clog2(ALARM_CNT) : 1;
    localparam int MASK_BIT  = BYTE_W - 1;

    typedef logic [BYTE_W-1:0]                  byte_t;
    typedef logic [FIELD_CNT-1:0][BYTE_W-1:0]   field_set_t;
    typedef logic [ALARM_CNT-1:0][FIELD_CNT-1:0][BYTE_W-1:0] alarm_bank_t;

    typedef struct packed {
        logic                 osc_stop;
        logic                 wp;
        logic                 route;
        logic [ALARM_CNT-1:0] en;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{osc_stop: 1'b1, wp: 1'b1, route: 1'b0, en: '0};

    function automatic byte_t ctrl_pack(input ctrl_t c);
        return {c.osc_stop, c.wp, 3'b000, c.route, c.en};
    endfunction

    function automatic logic field_pass(input byte_t alm, input byte_t now);
        return alm[MASK_BIT] | (alm[MASK_BIT-1:0] == now[MASK_BIT-1:0]);
    endfunction

endpackage

// File: rtl/rtc_alm_regs.sv
module rtc_alm_regs
    import rtc_alm_pkg::*;
#(
    parameter logic [REG_AW-1:0] CTRL_OFS = 7'h0F
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic [BYTE_W-1:0]    bus_addr,
    input  logic [BYTE_W-1:0]    bus_wdata,
    output ctrl_t                ctrl_q,
    output alarm_bank_t          alm_q,
    output logic [ALARM_CNT-1:0] alm_wr
);
    localparam int ALM_BYTES = ALARM_CNT * FIELD_CNT;

    logic [REG_AW-1:0] idx;
    logic              wr_req;
    logic              wr_ok;
    logic              unused_wdata;

    assign idx          = bus_addr[REG_AW-1:0];
    assign wr_req       = bus_sel & bus_addr[BYTE_W-1];
    assign wr_ok        = wr_req & ~ctrl_q.wp;
    assign unused_wdata = ^bus_wdata[5:3];

    // Control byte: under protection only the protect bit itself moves
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_req && idx == CTRL_OFS) begin
            ctrl_q.wp <= bus_wdata[6];
            if (!ctrl_q.wp) begin
                ctrl_q.osc_stop <= bus_wdata[7];
                ctrl_q.route    <= bus_wdata[2];
                ctrl_q.en       <= bus_wdata[ALARM_CNT-1:0];
            end
        end
    end

    // Alarm bytes
    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
        end else if (wr_ok && idx < REG_AW'(ALM_BYTES)) begin
            for (int a = 0; a < ALARM_CNT; a++) begin
                for (int f = 0; f < FIELD_CNT; f++) begin
                    if (idx == REG_AW'(a * FIELD_CNT + f))
                        alm_q[a][f] <= bus_wdata;
                end
            end
        end
    end

    // Per-alarm accepted write indication, used to drop its flag
    for (genvar a = 0; a < ALARM_CNT; a++) begin : g_wr
        localparam logic [REG_AW-1:0] BASE = REG_AW'(a * FIELD_CNT);
        localparam logic [REG_AW-1:0] LAST = REG_AW'(a * FIELD_CNT + FIELD_CNT - 1);
        assign alm_wr[a] = wr_ok && (idx >= BASE) && (idx <= LAST);
    end

    assert_wp_freezes_alarms_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.wp |=> $stable(alm_q));

    assert_wp_freezes_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.wp |=> ($stable(ctrl_q.osc_stop) && $stable(ctrl_q.route) && $stable(ctrl_q.en)));

endmodule

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp
    import rtc_alm_pkg::*;
(
    input  field_set_t alm,
    input  field_set_t now,
    output logic       hit
);
    logic [FIELD_CNT-1:0] pass;

    for (genvar f = 0; f < FIELD_CNT; f++) begin : g_fld
        assign pass[f] = field_pass(alm[f], now[f]);
    end

    assign hit = &pass;

endmodule

// File: rtl/rtc_alm_irq.sv
module rtc_alm_irq
    import rtc_alm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd,
    input  logic [ALARM_CNT-1:0] hit,
    input  logic                 clr_all,
    input  logic [ALARM_CNT-1:0] alm_wr,
    input  ctrl_t                ctrl,
    output logic [ALARM_CNT-1:0] flags,
    output logic                 irq0_n,
    output logic                 irq1_n
);
    logic [ALARM_CNT-1:0] req;

    for (genvar k = 0; k < ALARM_CNT; k++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[k] <= 1'b0;
            else if (upd && hit[k])
                flags[k] <= 1'b1;
            else if (clr_all || alm_wr[k])
                flags[k] <= 1'b0;
        end

        assert_flag_needs_match_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(flags[k]) |-> $past(upd && hit[k]));

        assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
            (flags[k] && !clr_all && !alm_wr[k]) |=> flags[k]);
    end

    assign req    = flags & ctrl.en;
    assign irq0_n = ~(req[0] | (~ctrl.route & req[1]));
    assign irq1_n = ~(ctrl.route & req[1]);

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en == '0) |-> (irq0_n && irq1_n));

endmodule

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
    import rtc_alm_pkg::*;
#(
    parameter logic [REG_AW-1:0] CTRL_OFS = 7'h0F,
    parameter logic [REG_AW-1:0] STAT_OFS = 7'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic [BYTE_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              stat_clr,
    input  logic              upd_tick,
    input  logic [BYTE_W-1:0] now_sec,
    input  logic [BYTE_W-1:0] now_min,
    input  logic [BYTE_W-1:0] now_hour,
    input  logic [BYTE_W-1:0] now_day,
    output logic              osc_stop,
    output logic              irq0_n,
    output logic              irq1_n
);
    localparam int ALM_BYTES = ALARM_CNT * FIELD_CNT;

    ctrl_t                ctrl_q;
    alarm_bank_t          alm_q;
    logic [ALARM_CNT-1:0] alm_wr;
    logic [ALARM_CNT-1:0] hit;
    logic [ALARM_CNT-1:0] flags;
    logic                 upd;
    field_set_t           now;
    logic [REG_AW-1:0]    ridx;

    assign now  = {now_day, now_hour, now_min, now_sec};
    assign upd  = upd_tick & ~ctrl_q.osc_stop;
    assign ridx = bus_addr[REG_AW-1:0];

    rtc_alm_regs #(.CTRL_OFS(CTRL_OFS)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl_q    (ctrl_q),
        .alm_q     (alm_q),
        .alm_wr    (alm_wr)
    );

    for (genvar a = 0; a < ALARM_CNT; a++) begin : g_cmp
        rtc_alm_cmp cmp_i (
            .alm (alm_q[a]),
            .now (now),
            .hit (hit[a])
        );
    end

    rtc_alm_irq irq_i (
        .clk     (clk),
        .rst     (rst),
        .upd     (upd),
        .hit     (hit),
        .clr_all (stat_clr),
        .alm_wr  (alm_wr),
        .ctrl    (ctrl_q),
        .flags   (flags),
        .irq0_n  (irq0_n),
        .irq1_n  (irq1_n)
    );

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[BYTE_W-1]) begin
            if (ridx == CTRL_OFS)
                bus_rdata = ctrl_pack(ctrl_q);
            else if (ridx == STAT_OFS)
                bus_rdata = BYTE_W'(flags);
            else if (ridx < REG_AW'(ALM_BYTES))
                bus_rdata = alm_q[ridx[FLD_AW +: ALM_AW]][ridx[FLD_AW-1:0]];
        end
    end

    assign osc_stop = ctrl_q.osc_stop;

    assert_stop_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.osc_stop |=> !$rose(flags[0]) && !$rose(flags[1]));

    assert_merged_irq1_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.route |-> irq1_n);

    assert_ctrl_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_addr[BYTE_W-1] && ridx == CTRL_OFS) |-> (bus_rdata[5:3] == 3'b000));

    assert_write_addr_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        bus_addr[BYTE_W-1] |-> (bus_rdata == '0));

endmodule

// File: tb/rtc_alarm_ctrl_tb.sv
module rtc_alarm_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       stat_clr = 1'b0;
    logic       upd_tick = 1'b0;
    logic [7:0] tm [4];
    logic       osc_stop, irq0_n, irq1_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    initial for (int i = 0; i < 4; i++) tm[i] = 8'h00;

    rtc_alarm_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat_clr(stat_clr),
        .upd_tick(upd_tick), .now_sec(tm[0]), .now_min(tm[1]),
        .now_hour(tm[2]), .now_day(tm[3]), .osc_stop(osc_stop),
        .irq0_n(irq0_n), .irq1_n(irq1_n)
    );

    // Behavioural reference model
    logic [7:0] m_alm [8];
    logic       m_stop, m_wp, m_route;
    logic [1:0] m_en, m_fl, m_set, m_clr;

    function automatic bit m_match(int k);
        for (int f = 0; f < 4; f++) begin
            if (!m_alm[k*4+f][7] && (m_alm[k*4+f][6:0] != tm[f][6:0])) return 0;
        end
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_alm[i] = 8'h00;
            m_stop = 1; m_wp = 1; m_route = 0; m_en = 0; m_fl = 0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                m_set[k] = upd_tick && !m_stop && m_match(k);
                m_clr[k] = stat_clr;
            end
            if (bus_sel && bus_addr[7]) begin
                if (bus_addr[6:0] == 7'h0F) begin
                    if (!m_wp) begin
                        m_stop = bus_wdata[7]; m_route = bus_wdata[2]; m_en = bus_wdata[1:0];
                    end
                    m_wp = bus_wdata[6];
                end else if (bus_addr[6:0] < 7'd8 && !m_wp) begin
                    m_alm[bus_addr[2:0]] = bus_wdata;
                    m_clr[bus_addr[2]] = 1'b1;
                end
            end
            for (int k = 0; k < 2; k++)
                if (m_set[k]) m_fl[k] = 1'b1;
                else if (m_clr[k]) m_fl[k] = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of register-driven outputs (R8, R10, R7)
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic e0, e1;
            e0 = !((m_fl[0] && m_en[0]) || (!m_route && m_fl[1] && m_en[1]));
            e1 = !(m_route && m_fl[1] && m_en[1]);
            chk(irq0_n === e0, "R8 R10 irq0_n per-cycle", irq0_n, e0);
            chk(irq1_n === e1, "R8 R10 irq1_n per-cycle", irq1_n, e1);
            chk(osc_stop === m_stop, "R3 osc_stop per-cycle", osc_stop, m_stop);
        end
    end

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_addr = {1'b1, a}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_addr = 8'h00; bus_wdata = 8'h00;
    endtask

    task automatic tick(input logic [7:0] s, m, h, d, input bit clr);
        @(negedge clk);
        tm[0] = s; tm[1] = m; tm[2] = h; tm[3] = d; upd_tick = 1; stat_clr = clr;
        @(negedge clk);
        upd_tick = 0; stat_clr = 0;
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        stat_clr = 1;
        @(negedge clk);
        stat_clr = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic rd_stat(input string tag);
        @(negedge clk);
        bus_addr = 8'h10;
        #1;
        chk(bus_rdata === {6'b0, m_fl}, tag, bus_rdata, {6'b0, m_fl});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd_chk(8'h0F, 8'hC0, "R1 control after reset");
        rd_chk(8'h10, 8'h00, "R1 status after reset");
        chk(irq0_n && irq1_n && osc_stop, "R1 outputs after reset", {irq0_n, irq1_n, osc_stop}, 3'b111);
        // R2 protection
        wr(7'h00, 8'h12);
        rd_chk(8'h00, 8'h00, "R2 alarm write refused");
        wr(7'h0F, 8'h07);
        rd_chk(8'h0F, 8'h80, "R2 only protect bit changes");
        // R3 full control write, pad bits zero
        wr(7'h0F, 8'hFF);
        rd_chk(8'h0F, 8'hC7, "R3 control write stored");
        wr(7'h0F, 8'h07);
        rd_chk(8'h0F, 8'h87, "R2 protect bit clears alone");
        // Alarm 0 fully masked
        for (int f = 0; f < 4; f++) wr(7'(f), 8'h80);
        rd_chk(8'h00, 8'h80, "R9 alarm 0 seconds address");
        // R5 stopped oscillator ignores ticks
        tick(8'h01, 8'h02, 8'h03, 8'h04, 0);
        rd_chk(8'h10, 8'h00, "R5 tick ignored while stopped");
        wr(7'h0F, 8'h07);
        // Alarm 1: seconds only
        wr(7'h04, 8'h30); wr(7'h05, 8'h85); wr(7'h06, 8'h80); wr(7'h07, 8'h80);
        rd_chk(8'h05, 8'h85, "R9 alarm 1 minutes address");
        tick(8'h31, 8'h05, 8'h03, 8'h04, 0);
        rd_chk(8'h10, 8'h01, "R4 every-second alarm only");
        chk(!irq0_n && irq1_n, "R7 alarm 0 drives irq0_n", {irq0_n, irq1_n}, 2'b01);
        repeat (3) @(negedge clk);
        rd_chk(8'h10, 8'h01, "R6 flag held");
        clr_pulse();
        rd_chk(8'h10, 8'h00, "R6 strobe clears flags");
        tick(8'h30, 8'h07, 8'h03, 8'h04, 0);
        rd_chk(8'h10, 8'h03, "R4 seconds-only match");
        chk(!irq0_n && !irq1_n, "R8 separate routing", {irq0_n, irq1_n}, 2'b00);
        clr_pulse();
        wr(7'h00, 8'h59);
        // Minutes and seconds
        wr(7'h05, 8'h05);
        tick(8'h30, 8'h06, 8'h03, 8'h04, 0);
        rd_chk(8'h10, 8'h00, "R4 minute mismatch");
        tick(8'h30, 8'h05, 8'h03, 8'h04, 0);
        rd_chk(8'h10, 8'h02, "R4 minutes and seconds match");
        clr_pulse();
        // Hours
        wr(7'h06, 8'h12);
        tick(8'h30, 8'h05, 8'h11, 8'h04, 0);
        rd_chk(8'h10, 8'h00, "R4 hour mismatch");
        tick(8'h30, 8'h05, 8'h12, 8'h04, 0);
        rd_stat("R4 hours match");
        clr_pulse();
        // Full day
        wr(7'h07, 8'h03);
        tick(8'h30, 8'h05, 8'h12, 8'h04, 0);
        rd_chk(8'h10, 8'h00, "R4 day mismatch");
        tick(8'h30, 8'h05, 8'h12, 8'h03, 0);
        rd_chk(8'h10, 8'h02, "R4 full day match");
        // R8 merged routing
        wr(7'h0F, 8'h03);
        chk(!irq0_n && irq1_n, "R8 merged onto irq0_n", {irq0_n, irq1_n}, 2'b01);
        // R7 enables off
        wr(7'h0F, 8'h04);
        rd_chk(8'h10, 8'h02, "R7 flag kept with enable off");
        chk(irq0_n && irq1_n, "R7 no interrupt when disabled", {irq0_n, irq1_n}, 2'b11);
        // R6 alarm rewrite clears its flag
        wr(7'h07, 8'h03);
        rd_chk(8'h10, 8'h00, "R6 alarm rewrite clears flag");
        // R6 set wins over clear
        tick(8'h30, 8'h05, 8'h12, 8'h03, 1);
        rd_chk(8'h10, 8'h02, "R6 set beats clear");
        // R9 unmapped and write-marked reads
        rd_chk(8'h20, 8'h00, "R9 unmapped read");
        rd_chk(8'h8F, 8'h00, "R9 write-marked read");
        // Stop and protect
        wr(7'h0F, 8'hC7);
        clr_pulse();
        tick(8'h30, 8'h05, 8'h12, 8'h03, 0);
        rd_chk(8'h10, 8'h00, "R5 stopped again, no flag");
        wr(7'h04, 8'h00);
        rd_chk(8'h04, 8'h30, "R2 protected alarm 1 byte");
        rd_chk(8'h0F, 8'hC7, "R3 control final");
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule